// File: doc/BRIEF.md
# Serializer Pin Controller with Local and Back-Channel Drive

This block owns four bidirectional general-purpose pins on the camera-side end of a serial video link. Two control registers decide how each pin behaves. A direction register holds one input-enable bit and one output-enable bit per pin. A data register holds one local output value and one remote-enable bit per pin. A pin whose remote enable is set takes its level from a four-bit word that the far-end receiver sends over the back channel. A pin whose remote enable is clear takes its level from the locally written value. The locally written value reaches the pad only when that pin's output enable is also set.

Software reaches the registers through a simple synchronous port with an 8-bit address and 8-bit data. Writes take effect on the clock edge that samples them. Read data is registered and appears one clock after the read strobe. The pad inputs are resynchronised and can be read back at a separate status address. The back-channel word is captured only on cycles where its valid strobe is high, and it is held between strobes.

Top module: `gpio_pin_router`

## Requirements
- R1: After reset both control registers read 0x00, every pad output enable is 0, every pad output is 0 and the read data is 0x00.
- R2: The direction register at address 0x0E reads back its last written value; bit 4+i is the output enable of pin i and drives padOe[i] from the cycle after the write.
- R3: The data register at address 0x0D reads back its last written value; bit 4+i is the remote enable of pin i and bit i is the local output value of pin i.
- R4: A pin with output enable 1 and remote enable 0 drives its local value bit. Writing 0xF0 to 0x0E and then 0x0F to 0x0D drives all four pads high.
- R5: A pin with output enable 0 drives padOut 0 and padOe 0, whatever its local value bit holds.
- R6: A pin with remote enable 1 and output enable 1 drives the bit of the last captured back-channel word; its local value bit has no effect. Writing 0xF0 to 0x0D puts all four pins under remote control.
- R7: The back-channel word is captured on a clock edge where bcValid is 1 and held unchanged while bcValid is 0.
- R8: padOe[i] follows output-enable bit i in remote mode exactly as in local mode.
- R9: Pad inputs pass through two synchronizing flops. The status address 0x1C returns the synchronized inputs in bits [3:0] and 0 in bits [7:4]. A level applied before one read strobe is not visible in that read and is visible in a read issued three cycles later.
- R10: A pin whose input-enable bit (direction bit i) is 0 reads as 0 in the status word.
- R11: A write to any address other than 0x0E and 0x0D changes no register. A read of any address other than 0x0E, 0x0D and 0x1C returns 0x00.
- R12: regRdata updates only on the clock edge after a cycle with regRe high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Registered read data |
| bcData | input | 4 | Pin levels recovered from the back channel |
| bcValid | input | 1 | Capture strobe for bcData |
| padIn | input | 4 | Pad input levels, asynchronous |
| padOut | output | 4 | Pad output levels |
| padOe | output | 4 | Pad output enables |

## Verification
The bench goes after the places where the two control bits of a pin interact. A pin that is remote-enabled but was handed its local bit would show the written value instead of the back-channel word. A mixed word with two remote and two local pins catches a design that applies the remote enables to the wrong half of the byte. A disabled output that leaks its local value would show a high level with padOe low. Further checks cover a back-channel word changing with no strobe, which must not move the pins, and a status read with inputs disabled, which must mask to zero. Writes to an unmapped address are checked for side effects, and the first status read after an input change is checked for data that arrives too early through a missing synchronizer stage.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // Strobes passed from the address decoder to the datapath.
  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic rdDir;
    logic rdData;
    logic rdStat;
    logic rdLoad;
  } gprStrobe_t;

endpackage

// File: rtl/gpr_sync.sv
module gpr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
  import gpr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  DIR_ADDR  = 8'h0E,
  parameter logic [7:0]  DATA_ADDR = 8'h0D,
  parameter logic [7:0]  STAT_ADDR = 8'h1C
) (
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  output gprStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] DirA  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);

  logic hitDir, hitData, hitStat;

  always_comb begin
    hitDir  = (regAddr == DirA);
    hitData = (regAddr == DataA);
    hitStat = (regAddr == StatA);
    strb.wrDir  = regWe & hitDir;
    strb.wrData = regWe & hitData;
    strb.rdDir  = regRe & hitDir;
    strb.rdData = regRe & hitData;
    strb.rdStat = regRe & hitStat;
    strb.rdLoad = regRe;
  end

endmodule

// File: rtl/gpr_datapath.sv
module gpr_datapath
  import gpr_pkg::*;
#(
  parameter int PINS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W = 2 * PINS
) (
  input  logic              clk,
  input  logic              rstN,
  input  gprStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [PINS-1:0]   bcData,
  input  logic              bcValid,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [DATA_W-1:0] dirQ,
  output logic [DATA_W-1:0] dataQ
);

  logic [PINS-1:0]   remoteQ;
  logic [PINS-1:0]   inSync;
  logic [PINS-1:0]   inEn, outEn, rmtEn, localVal;
  logic [DATA_W-1:0] rdNext;

  // Control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strb.wrDir)  dirQ  <= wdata;
      if (strb.wrData) dataQ <= wdata;
    end
  end

  assign inEn     = dirQ[PINS-1:0];
  assign outEn    = dirQ[DATA_W-1:PINS];
  assign localVal = dataQ[PINS-1:0];
  assign rmtEn    = dataQ[DATA_W-1:PINS];

  // Back-channel capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        remoteQ <= '0;
    else if (bcValid) remoteQ <= bcData;
  end

  // Pad input synchronizer
  gpr_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (inSync)
  );

  // Per-pin output selection
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic srcBit;
    always_comb begin
      srcBit    = rmtEn[p] ? remoteQ[p] : localVal[p];
      padOe[p]  = outEn[p];
      padOut[p] = outEn[p] & srcBit;
    end
  end

  // Read path
  always_comb begin
    rdNext = '0;
    if (strb.rdDir)  rdNext = dirQ;
    if (strb.rdData) rdNext = dataQ;
    if (strb.rdStat) rdNext = {{PINS{1'b0}}, inSync & inEn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdata <= '0;
    else if (strb.rdLoad) rdata <= rdNext;
  end

endmodule

// File: rtl/gpio_pin_router.sv
module gpio_pin_router
  import gpr_pkg::*;
#(
  parameter int         PINS      = 4,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] DIR_ADDR  = 8'h0E,
  parameter logic [7:0] DATA_ADDR = 8'h0D,
  parameter logic [7:0] STAT_ADDR = 8'h1C,
  localparam int        DATA_W    = 2 * PINS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [PINS-1:0]   bcData,
  input  logic              bcValid,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe
);

  gprStrobe_t        strb;
  logic [DATA_W-1:0] dirQ;
  logic [DATA_W-1:0] dataQ;

  gpr_ctrl #(
    .ADDR_W    (ADDR_W),
    .DIR_ADDR  (DIR_ADDR),
    .DATA_ADDR (DATA_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_ctrl (
    .regWe   (regWe),
    .regRe   (regRe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpr_datapath #(.PINS(PINS), .SYNC_STAGES(2)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (regWdata),
    .rdata   (regRdata),
    .bcData  (bcData),
    .bcValid (bcValid),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .dirQ    (dirQ),
    .dataQ   (dataQ)
  );

endmodule

// File: rtl/gpr_checker.sv
module gpr_checker #(
  parameter int         PINS      = 4,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] DIR_ADDR  = 8'h0E,
  parameter logic [7:0] DATA_ADDR = 8'h0D,
  parameter logic [7:0] STAT_ADDR = 8'h1C,
  localparam int        DATA_W    = 2 * PINS
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              regRe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic [PINS-1:0]   bcData,
  input logic              bcValid,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOe,
  input logic [DATA_W-1:0] dirQ,
  input logic [DATA_W-1:0] dataQ
);

  localparam logic [ADDR_W-1:0] DirA  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);

  logic [PINS-1:0] rmtMask;
  assign rmtMask = dataQ[DATA_W-1:PINS];

  // R2: direction write reaches the pad enables one cycle later
  p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == DirA) |=> (padOe == $past(regWdata[DATA_W-1:PINS])));

  // R4: local value reaches all-output pins when no remote enable is written
  p_local_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == DataA && regWdata[DATA_W-1:PINS] == '0 && (&padOe))
    |=> (padOut == $past(regWdata[PINS-1:0])));

  // R6: remote-enabled output pins follow the captured back-channel word
  p_remote_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bcValid && !regWe) |=>
    ((padOut & rmtMask & padOe) == ($past(bcData) & rmtMask & padOe)));

  // R7: with no strobe and no write, the pins hold
  p_remote_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!bcValid && !regWe) |=> $stable(padOut));

  // R10: disabled inputs and the upper nibble read as zero
  p_stat_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == StatA) |=>
    ((regRdata[PINS-1:0] & ~$past(dirQ[PINS-1:0])) == '0 &&
     regRdata[DATA_W-1:PINS] == '0));

  // R11: writes to unmapped addresses change no register
  p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr != DirA && regAddr != DataA) |=>
    ($stable(dirQ) && $stable(dataQ)));

  // R12: read data holds without a read strobe
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !regRe |=> $stable(regRdata));

endmodule

bind gpio_pin_router gpr_checker #(
  .PINS      (PINS),
  .ADDR_W    (ADDR_W),
  .DIR_ADDR  (DIR_ADDR),
  .DATA_ADDR (DATA_ADDR),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regRe    (regRe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .bcData   (bcData),
  .bcValid  (bcValid),
  .padOut   (padOut),
  .padOe    (padOe),
  .dirQ     (dirQ),
  .dataQ    (dataQ)
);

// File: tb/gpio_pin_router_tb.sv
module gpio_pin_router_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic       regRe = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [3:0] bcData = 4'h0;
  logic       bcValid = 1'b0;
  logic [3:0] padIn = 4'h0;
  logic [3:0] padOut;
  logic [3:0] padOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pin_router u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regRe    (regRe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .bcData   (bcData),
    .bcValid  (bcValid),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    @(negedge clk);
    regRe = 1'b0;
    d = regRdata;
  endtask

  task automatic pulseBc(input logic [3:0] d);
    @(negedge clk);
    bcData = d; bcValid = 1'b1;
    @(negedge clk);
    bcValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(padOe == 4'h0, "R1 padOe", padOe, 0);
    check(padOut == 4'h0, "R1 padOut", padOut, 0);
    check(regRdata == 8'h00, "R1 rdata", regRdata, 0);
    readReg(8'h0E, v); check(v == 8'h00, "R1 dir", v, 0);
    readReg(8'h0D, v); check(v == 8'h00, "R1 data", v, 0);
  endtask

  task automatic t_local();
    logic [7:0] v;
    writeReg(8'h0E, 8'hF0);
    check(padOe == 4'hF, "R2 padOe", padOe, 4'hF);
    readReg(8'h0E, v); check(v == 8'hF0, "R2 readback", v, 8'hF0);
    writeReg(8'h0D, 8'h0F);
    check(padOut == 4'hF, "R4 all high", padOut, 4'hF);
    readReg(8'h0D, v); check(v == 8'h0F, "R3 readback", v, 8'h0F);
    writeReg(8'h0D, 8'h05);
    check(padOut == 4'h5, "R4 pattern", padOut, 4'h5);
  endtask

  task automatic t_oeMask();
    writeReg(8'h0E, 8'h30);
    writeReg(8'h0D, 8'h0F);
    check(padOut == 4'h3, "R5 masked out", padOut, 4'h3);
    check(padOe == 4'h3, "R5 masked oe", padOe, 4'h3);
  endtask

  task automatic t_remote();
    writeReg(8'h0E, 8'hF0);
    pulseBc(4'hA);
    writeReg(8'h0D, 8'hF0);
    check(padOut == 4'hA, "R6 all remote", padOut, 4'hA);
    writeReg(8'h0D, 8'hF5);
    check(padOut == 4'hA, "R6 local ignored", padOut, 4'hA);
    // pins 0,1 remote (A -> 2'b10), pins 2,3 local high
    writeReg(8'h0D, 8'h3F);
    check(padOut == 4'hE, "R6 mixed", padOut, 4'hE);
  endtask

  task automatic t_hold();
    writeReg(8'h0D, 8'hF0);
    @(negedge clk); bcData = 4'h5;
    repeat (3) @(negedge clk);
    check(padOut == 4'hA, "R7 held", padOut, 4'hA);
    pulseBc(4'h5);
    check(padOut == 4'h5, "R7 captured", padOut, 4'h5);
  endtask

  task automatic t_remoteOe();
    writeReg(8'h0E, 8'h00);
    check(padOe == 4'h0, "R8 oe off", padOe, 0);
    check(padOut == 4'h0, "R8 out off", padOut, 0);
    writeReg(8'h0E, 8'h90);
    check(padOe == 4'h9, "R8 oe on", padOe, 4'h9);
    check(padOut == 4'h1, "R8 out", padOut, 4'h1);
  endtask

  task automatic t_inputs();
    logic [7:0] v;
    writeReg(8'h0E, 8'h0F);
    @(negedge clk); padIn = 4'h9;
    readReg(8'h1C, v); check(v == 8'h00, "R9 not yet", v, 0);
    repeat (3) @(negedge clk);
    readReg(8'h1C, v); check(v == 8'h09, "R9 status", v, 8'h09);
    writeReg(8'h0E, 8'h03);
    readReg(8'h1C, v); check(v == 8'h01, "R10 masked", v, 8'h01);
    writeReg(8'h0E, 8'h00);
    readReg(8'h1C, v); check(v == 8'h00, "R10 all off", v, 0);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    writeReg(8'h0E, 8'hC0);
    writeReg(8'h0D, 8'h0A);
    writeReg(8'h0C, 8'hFF);
    writeReg(8'h0F, 8'hFF);
    check(padOe == 4'hC, "R11 oe kept", padOe, 4'hC);
    check(padOut == 4'h8, "R11 out kept", padOut, 4'h8);
    readReg(8'h0E, v); check(v == 8'hC0, "R11 dir kept", v, 8'hC0);
    readReg(8'h0D, v); check(v == 8'h0A, "R11 data kept", v, 8'h0A);
    readReg(8'h55, v); check(v == 8'h00, "R11 unmapped read", v, 0);
  endtask

  task automatic t_rdHold();
    logic [7:0] v;
    readReg(8'h0E, v);
    @(negedge clk); regAddr = 8'h0D;
    repeat (2) @(negedge clk);
    check(regRdata == 8'hC0, "R12 hold", regRdata, 8'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_local();
    t_oeMask();
    t_remote();
    t_hold();
    t_remoteOe();
    t_inputs();
    t_unmapped();
    t_rdHold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule